// File: doc/BRIEF.md
# Right-Justified Mono Serial Word Receiver

This block is the input stage of a converter datapath. It takes three wires from a host: a bit clock, serial data, and a word clock. Data is shifted in most significant bit first on every rising edge of the bit clock. The shifting never pauses. Each high-to-low transition of the word clock closes a word. The word that is kept is made of the 16 bits received just before that transition. Because of this the format is right-justified: a frame may be longer than 16 bit-clock periods, and the surplus leading bits simply fall off the top of the register.

The captured word is held in a temporary register. It is then forwarded downstream one and a half bit-clock periods after the word-clock transition, which is on the second rising bit-clock edge that follows it. At that edge a one-cycle transfer strobe and a frame marker are raised together with the word. The downstream consumer is either an interpolation filter or the converter latch. The whole block runs in the bit-clock domain. Data words are 16-bit two's complement, and the receiver passes them through unchanged.

Top module: `rj_serial_rx`

## Requirements
- R1: On every rising bit-clock edge the sampled `sdata` bit enters the shift register at the least significant end, so the bits of a word arrive most significant bit first.
- R2: A word-clock falling edge is recognised at rising edge k of the bit clock when `wclk` is sampled 0 at edge k and was sampled 1 at edge k-1. The captured word is made of the 16 bits sampled at edges k-16 through k-1, with the bit sampled at edge k-1 as bit 0.
- R3: For a falling edge recognised at edge k, `xfer_o` is high for exactly the one cycle that follows edge k+1. It is never high in two consecutive cycles.
- R4: During that cycle `word_o` carries the captured word. `word_o` changes at no other time and otherwise holds the last forwarded word.
- R5: `frame_o` is high in exactly the same cycles as `xfer_o`.
- R6: While `rst_n` is low, `word_o` is 0000 hex and both strobes are low. After reset the shift register reads as all zeros, and the word clock counts as having been low.
- R7: No strobe is produced while the word clock stays high, stays low, or rises.
- R8: Frames longer than 16 bit clocks are legal. Two's-complement extremes such as 7FFF hex (positive full scale), 8000 hex (negative full scale) and 0000 hex (mid-scale) are forwarded bit-exact.
- R9: Frames as short as two bit clocks are accepted. Each such frame yields its own strobe, built from the 16 most recent bits even when these span earlier frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; every register uses its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata | input | 1 | Serial data, most significant bit first |
| wclk | input | 1 | Word clock; its falling edge closes a word |
| word_o | output | 16 | Forwarded data word, two's complement |
| xfer_o | output | 1 | One-cycle transfer strobe |
| frame_o | output | 1 | Frame marker, coincident with the transfer strobe |

## Verification
The hardest situation to reach from the ports is a word-clock falling edge that arrives while earlier history still sits in the shift register. This covers frames much shorter than 16 bits, where the captured word mixes bits from several earlier frames, and long frames whose leading bits must be discarded. The stimulus draws frame lengths at random between 2 and 40 bits, filled with random data. Directed runs are interleaved with the random frames: full-scale codes, a 24-bit frame with junk leading bits, minimum-length frames sent back to back, and long stretches with the word clock held constant. A bench-side bit history predicts every capture and the cycle in which it appears.

// File: rtl/rj_serial_rx.sv
module rj_serial_rx #(
  parameter int WORD_W = 16
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              sdata,
  input  logic              wclk,
  output logic [WORD_W-1:0] word_o,
  output logic              xfer_o,
  output logic              frame_o
);

  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] hold;
  logic              wclk_q;
  logic              pend;
  logic              fall;

  assign fall = wclk_q & ~wclk;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      wclk_q <= 1'b0;
    end else begin
      shreg  <= {shreg[WORD_W-2:0], sdata};
      wclk_q <= wclk;
    end
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0;
    end else if (fall) begin
      hold <= shreg;
    end
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      xfer_o  <= 1'b0;
      frame_o <= 1'b0;
      word_o  <= '0;
    end else begin
      pend    <= fall;
      xfer_o  <= pend;
      frame_o <= pend;
      if (pend) word_o <= hold;
    end
  end

  // R3
  xfer_after_fall_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    xfer_o |-> $past(fall, 2));

  // R3
  xfer_single_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    xfer_o |=> !xfer_o);

  // R2
  word_capture_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    xfer_o |-> word_o == $past(shreg, 2));

  // R4
  word_hold_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    !$stable(word_o) |-> xfer_o);

  // R5
  frame_align_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    frame_o == xfer_o);

  // R7
  no_strobe_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    (!$past(wclk_q, 2) || $past(wclk, 2)) |-> !xfer_o);

endmodule

// File: tb/rj_serial_rx_bench.sv
module rj_serial_rx_bench;

  logic        bclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sdata = 1'b0;
  logic        wclk = 1'b0;
  logic [15:0] word_o;
  logic        xfer_o;
  logic        frame_o;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [15:0] hist = '0;
  logic        prev_w = 1'b0;
  logic        p0_x = 1'b0, p1_x = 1'b0;
  logic [15:0] p0_w = '0, p1_w = '0;
  logic [15:0] exp_word = '0;

  always #10 bclk = ~bclk;

  rj_serial_rx u_rj_serial_rx (
    .bclk(bclk), .rst_n(rst_n), .sdata(sdata), .wclk(wclk),
    .word_o(word_o), .xfer_o(xfer_o), .frame_o(frame_o)
  );

  function automatic logic [15:0] push_bit(input logic [15:0] h, input logic b);
    return {h[14:0], b};
  endfunction

  function automatic logic is_close(input logic pw, input logic w);
    return pw & ~w;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input logic b, input logic w);
    @(negedge bclk);
    check("R3", {15'd0, xfer_o}, {15'd0, p1_x});
    check("R5", {15'd0, frame_o}, {15'd0, p1_x});
    if (p1_x) exp_word = p1_w;
    check(p1_x ? "R2" : "R4", word_o, exp_word);
    p1_x = p0_x;
    p1_w = p0_w;
    p0_x = is_close(prev_w, w);
    p0_w = hist;
    hist = push_bit(hist, b);
    prev_w = w;
    sdata = b;
    wclk = w;
  endtask

  task automatic send_frame(input logic [63:0] bits, input int len);
    for (int i = 0; i < len; i++) begin
      tick(bits[len-1-i], (i >= len/2));
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge bclk);
    // R6 reset state
    check("R6", word_o, 16'h0000);
    check("R6", {15'd0, xfer_o}, 16'h0000);
    check("R6", {15'd0, frame_o}, 16'h0000);
    rst_n = 1'b1;

    // R8 full-scale and mid-scale codes, R1 bit order
    send_frame(64'h7FFF, 16);
    tick(1'b0, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    check("R8", word_o, 16'h7FFF);
    send_frame(64'h8000, 16);
    tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b1, 1'b0);
    check("R8", word_o, 16'h8000);
    send_frame(64'h0000, 16);
    tick(1'b0, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    check("R8", word_o, 16'h0000);

    // R8 long frame: junk leading bits are discarded
    send_frame(64'hA5_1234, 24);
    tick(1'b0, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    check("R8", word_o, 16'h1234);

    // R7 word clock held high, then low: no strobe
    for (int i = 0; i < 50; i++) tick(1'($urandom), 1'b1);
    for (int i = 0; i < 50; i++) tick(1'($urandom), 1'b0);

    // R9 minimum-length frames back to back
    for (int i = 0; i < 40; i++) send_frame(64'($urandom % 4), 2);

    // R1 R2 random frame lengths and data
    for (int f = 0; f < 600; f++) begin
      send_frame({$urandom, $urandom}, 2 + int'($urandom % 39));
    end
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule